// File: doc/BRIEF.md
# Multi-Core Interrupt Distributor

This block collects interrupt lines from peripherals, keeps an enable bit, a pending state, a trigger mode and a CPU routing byte for each line, and presents to every CPU the lowest-numbered interrupt that is pending, enabled and routed to it. Lines come in groups of 32 (`NUM_GROUPS`) and there are up to eight CPUs (`NUM_CPUS`). IDs 0 to 15 are software interrupts, raised only by writing a packed command word. IDs 16 to 31 are fixed level-sensitive lines. IDs 32 and up are shared lines whose trigger mode software picks.

Software reaches the block through a flat 32-bit register port with a word address. A write takes effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. The CPU interface pulses `cpu_ack[c]` to take the interrupt it is being shown. Register word addresses: control 0x000, type 0x001, enable-set 0x040+g, enable-clear 0x080+g, pending-clear 0x0C0+g, trigger 0x100+k, target 0x200+w, software interrupt 0x3C0.

Top module: `irqd_top`

## Requirements
- R1: At 0x040+g a 1 in bit i enables ID 32g+i. At 0x080+g a 1 disables it. A 0 bit changes nothing. Both words read back the enable state. All IDs are disabled after reset.
- R2: At 0x0C0+g a 1 in bit i discards the latched pending state of ID 32g+i. For IDs below 16 it clears that software interrupt in every CPU. The word reads back the pending view: the line state for IDs 16 and up, and the OR over CPUs for IDs below 16.
- R3: Word 0x001 reads NUM_GROUPS-1 in bits [4:0] and NUM_CPUS-1 in bits [7:5].
- R4: At 0x100+k, bit 2i+1 sets the mode of ID 16k+i: 1 is edge, 0 is level. Bit 2i reads 0. Every line resets to level. IDs below 32 stay level: they read 0 and ignore writes.
- R5: An edge-mode line latches pending on a rising input and holds it until it is cleared. A level-mode line is pending exactly while its input is high.
- R6: At 0x200+w, byte b (bits 8b+7:8b) holds the CPU mask of ID 4w+b, with bit c meaning CPU c. IDs 16 and up reset to 0x01. IDs below 16 read 0 and ignore writes.
- R7: A write to 0x3C0 carries the filter in [25:24], the CPU list in [23:16] and the ID in [3:0]. Bit 15 has no effect. Filter 0 selects the listed CPUs, 1 selects all CPUs except `reg_src_cpu`, 2 selects only `reg_src_cpu`, and 3 selects none. Each selected CPU gets its own pending bit for that ID.
- R8: Bit 0 of 0x000 enables forwarding and resets to 0. While it is 0, no `cpu_irq_valid` is raised.
- R9: Each CPU is shown the lowest ID that is pending, enabled and routed to it. Software interrupts count as routed to the CPUs whose own bit is set.
- R10: `cpu_ack[c]` while `cpu_irq_valid[c]` is high clears the presented ID. For an edge line it clears the latched pending state. For a software interrupt it clears CPU c's bit. A level line is unaffected.
- R11: A register write or an acknowledge at edge E changes the outputs at edge E+1. An input change sampled at edge E shows at edge E+1.
- R12: Inputs `irq_in[15:0]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32*NUM_GROUPS | Peripheral interrupt inputs, bit n is ID n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_src_cpu | input | 3 | Number of the CPU issuing the write |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpu_ack | input | NUM_CPUS | Per-CPU acknowledge of the presented ID |
| cpu_irq_valid | output | NUM_CPUS | Per-CPU interrupt request |
| cpu_irq_id | output | NUM_CPUS*ID_W | Per-CPU presented ID, CPU c in bits [c*ID_W +: ID_W] |

## Verification
A write or an acknowledge is applied on one edge, and the CPU outputs change on the next edge. The bench drives stimulus at falling edges, so these results are sampled one falling edge after the write or acknowledge task returns. A peripheral input is sampled on the first rising edge and shows on the second. One check confirms that the output has not yet changed after the first edge and has changed after the second, and every other input check waits two falling edges. Register reads are combinational and are sampled a fraction of a period after the address is set.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_INFO  = 12'h001;
  localparam logic [ADDR_W-1:0] A_ENSET = 12'h040;
  localparam logic [ADDR_W-1:0] A_ENCLR = 12'h080;
  localparam logic [ADDR_W-1:0] A_PCLR  = 12'h0C0;
  localparam logic [ADDR_W-1:0] A_TRIG  = 12'h100;
  localparam logic [ADDR_W-1:0] A_TGT   = 12'h200;
  localparam logic [ADDR_W-1:0] A_SWI   = 12'h3C0;

  localparam int unsigned SWI_IDS    = 16;
  localparam int unsigned FIXED_IDS  = 32;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_NONE   = 2'd3
  } swi_filter_e;
endpackage

// File: rtl/irqd_lines.sv
module irqd_lines
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  localparam int unsigned N = 32 * NUM_GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [N-1:0]      ack_clr,
  output logic [N-1:0]      line_en,
  output logic [N-1:0]      line_pend,
  output logic [N-1:0]      line_edge,
  output logic [8*N-1:0]    line_tgt
);
  logic [N-1:0]   en_q, en_d, lat_q, lat_d, edg_q, edg_d, smp_q, smp_d;
  logic [N-1:0]   pclr, rise;
  logic [8*N-1:0] tgt_q, tgt_d;

  always_comb begin
    en_d  = en_q;
    edg_d = edg_q;
    tgt_d = tgt_q;
    pclr  = '0;
    smp_d = irq_in;
    smp_d[SWI_IDS-1:0] = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_we && reg_addr == A_ENSET + ADDR_W'(g))
        en_d[g*32 +: 32] = en_q[g*32 +: 32] | reg_wdata;
      if (reg_we && reg_addr == A_ENCLR + ADDR_W'(g))
        en_d[g*32 +: 32] = en_q[g*32 +: 32] & ~reg_wdata;
      if (reg_we && reg_addr == A_PCLR + ADDR_W'(g))
        pclr[g*32 +: 32] = reg_wdata;
    end
    for (int k = 0; k < 2 * NUM_GROUPS; k++) begin
      if (reg_we && reg_addr == A_TRIG + ADDR_W'(k)) begin
        for (int i = 0; i < 16; i++) begin
          if (16 * k + i >= FIXED_IDS) edg_d[16*k+i] = reg_wdata[2*i+1];
        end
      end
    end
    for (int w = 0; w < 8 * NUM_GROUPS; w++) begin
      if (reg_we && reg_addr == A_TGT + ADDR_W'(w)) begin
        for (int b = 0; b < 4; b++) begin
          if (4 * w + b >= SWI_IDS) tgt_d[(4*w+b)*8 +: 8] = reg_wdata[8*b +: 8];
        end
      end
    end
    rise  = irq_in & ~smp_q & edg_q;
    lat_d = (lat_q & ~(pclr | ack_clr)) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lat_q <= '0;
      edg_q <= '0;
      smp_q <= '0;
      for (int i = 0; i < N; i++) tgt_q[i*8 +: 8] <= (i >= SWI_IDS) ? 8'h01 : 8'h00;
    end else begin
      en_q  <= en_d;
      lat_q <= lat_d;
      edg_q <= edg_d;
      smp_q <= smp_d;
      tgt_q <= tgt_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pend
    if (i < SWI_IDS) begin : g_soft
      assign line_pend[i] = 1'b0;
    end else if (i < FIXED_IDS) begin : g_fixed
      assign line_pend[i] = smp_q[i];
    end else begin : g_shared
      assign line_pend[i] = edg_q[i] ? lat_q[i] : smp_q[i];
    end
  end

  assign line_en   = en_q;
  assign line_edge = edg_q;
  assign line_tgt  = tgt_q;
endmodule

// File: rtl/irqd_swi.sv
module irqd_swi
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned ID_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     swi_we,
  input  logic [1:0]               swi_filter,
  input  logic [NUM_CPUS-1:0]      swi_list,
  input  logic [3:0]               swi_id,
  input  logic [2:0]               src_cpu,
  input  logic [15:0]              pclr_mask,
  input  logic [NUM_CPUS-1:0]      ack,
  input  logic [NUM_CPUS*ID_W-1:0] ack_id,
  output logic [NUM_CPUS*16-1:0]   swi_pend
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic        hit;
    logic [15:0] pend_q, pend_d, clr;
    logic [ID_W-1:0] aid;

    assign aid = ack_id[c*ID_W +: ID_W];

    always_comb begin
      unique case (swi_filter_e'(swi_filter))
        FLT_LIST:   hit = swi_list[c];
        FLT_OTHERS: hit = (src_cpu != 3'(c));
        FLT_SELF:   hit = (src_cpu == 3'(c));
        default:    hit = 1'b0;
      endcase
      clr = pclr_mask;
      if (ack[c] && aid < ID_W'(SWI_IDS)) clr[aid[3:0]] = 1'b1;
      pend_d = pend_q & ~clr;
      if (swi_we && hit) pend_d[swi_id] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
    end

    assign swi_pend[c*16 +: 16] = pend_q;
  end
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int unsigned N        = 64,
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned ID_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fwd_en,
  input  logic [N-1:0]             line_en,
  input  logic [N-1:0]             line_pend,
  input  logic [8*N-1:0]           line_tgt,
  input  logic [NUM_CPUS*16-1:0]   swi_pend,
  output logic [NUM_CPUS-1:0]      out_valid,
  output logic [NUM_CPUS*ID_W-1:0] out_id
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [N-1:0]    cand;
    logic            found, v_q;
    logic [ID_W-1:0] idx, id_q;

    always_comb begin
      for (int i = 0; i < 16; i++) cand[i] = swi_pend[c*16+i] & line_en[i];
      for (int i = 16; i < N; i++) cand[i] = line_pend[i] & line_en[i] & line_tgt[i*8+c];
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (cand[i]) begin
          found = 1'b1;
          idx   = ID_W'(i);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        id_q <= '0;
      end else begin
        v_q  <= found & fwd_en;
        id_q <= idx;
      end
    end

    assign out_valid[c]            = v_q;
    assign out_id[c*ID_W +: ID_W]  = id_q;
  end
endmodule

// File: rtl/irqd_top.sv
module irqd_top
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned NUM_CPUS   = 4,
  localparam int unsigned N    = 32 * NUM_GROUPS,
  localparam int unsigned ID_W = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             irq_in,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  input  logic [2:0]               reg_src_cpu,
  output logic [31:0]              reg_rdata,
  input  logic [NUM_CPUS-1:0]      cpu_ack,
  output logic [NUM_CPUS-1:0]      cpu_irq_valid,
  output logic [NUM_CPUS*ID_W-1:0] cpu_irq_id
);
  logic [1:0]  rst_q;
  logic        rst_sync_n;
  logic        ctrl_q, ctrl_d;
  logic [N-1:0] line_en, line_pend, line_edge, ack_clr, pend_view;
  logic [8*N-1:0] line_tgt;
  logic [NUM_CPUS*16-1:0] swi_pend;
  logic [NUM_CPUS-1:0] ack_ok;
  logic [15:0] swi_pclr, swi_any;
  logic        swi_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we && reg_addr == A_CTRL) ctrl_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= 1'b0;
    else             ctrl_q <= ctrl_d;
  end

  always_comb begin
    ack_clr = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      ack_ok[c] = cpu_ack[c] & cpu_irq_valid[c];
      if (ack_ok[c]) ack_clr[cpu_irq_id[c*ID_W +: ID_W]] = 1'b1;
    end
  end

  assign swi_we   = reg_we && (reg_addr == A_SWI);
  assign swi_pclr = (reg_we && reg_addr == A_PCLR) ? reg_wdata[15:0] : 16'h0;

  irqd_lines #(.NUM_GROUPS(NUM_GROUPS)) u_lines (
    .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ack_clr(ack_clr), .line_en(line_en), .line_pend(line_pend),
    .line_edge(line_edge), .line_tgt(line_tgt)
  );

  irqd_swi #(.NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_swi (
    .clk(clk), .rst_n(rst_sync_n), .swi_we(swi_we),
    .swi_filter(reg_wdata[25:24]), .swi_list(reg_wdata[16 +: NUM_CPUS]),
    .swi_id(reg_wdata[3:0]), .src_cpu(reg_src_cpu), .pclr_mask(swi_pclr),
    .ack(ack_ok), .ack_id(cpu_irq_id), .swi_pend(swi_pend)
  );

  irqd_pick #(.N(N), .NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_pick (
    .clk(clk), .rst_n(rst_sync_n), .fwd_en(ctrl_q),
    .line_en(line_en), .line_pend(line_pend), .line_tgt(line_tgt),
    .swi_pend(swi_pend), .out_valid(cpu_irq_valid), .out_id(cpu_irq_id)
  );

  always_comb begin
    swi_any = '0;
    for (int c = 0; c < NUM_CPUS; c++) swi_any = swi_any | swi_pend[c*16 +: 16];
    pend_view = line_pend;
    pend_view[15:0] = swi_any;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata[0] = ctrl_q;
    if (reg_addr == A_INFO) begin
      reg_rdata[4:0] = 5'(NUM_GROUPS - 1);
      reg_rdata[7:5] = 3'(NUM_CPUS - 1);
    end
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr == A_ENSET + ADDR_W'(g) || reg_addr == A_ENCLR + ADDR_W'(g))
        reg_rdata = line_en[g*32 +: 32];
      if (reg_addr == A_PCLR + ADDR_W'(g))
        reg_rdata = pend_view[g*32 +: 32];
    end
    for (int k = 0; k < 2 * NUM_GROUPS; k++) begin
      if (reg_addr == A_TRIG + ADDR_W'(k)) begin
        for (int i = 0; i < 16; i++) reg_rdata[2*i+1] = line_edge[16*k+i];
      end
    end
    for (int w = 0; w < 8 * NUM_GROUPS; w++) begin
      if (reg_addr == A_TGT + ADDR_W'(w)) reg_rdata = line_tgt[w*32 +: 32];
    end
  end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned NUM_CPUS   = 4,
  localparam int unsigned N = 32 * NUM_GROUPS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [31:0]            reg_wdata,
  input logic [31:0]            reg_rdata,
  input logic                   ctrl_q,
  input logic [N-1:0]           line_en,
  input logic [NUM_CPUS*16-1:0] swi_pend,
  input logic [NUM_CPUS-1:0]    cpu_ack,
  input logic [NUM_CPUS-1:0]    cpu_irq_valid
);
  // R8
  fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q |=> cpu_irq_valid == '0);

  // R1
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ENSET) |=> ((line_en[31:0] & $past(reg_wdata)) == $past(reg_wdata)));

  // R1
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ENCLR) |=> ((line_en[31:0] & $past(reg_wdata)) == 32'h0));

  // R7
  swi_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SWI && reg_wdata[25:24] == 2'b11 && cpu_ack == '0)
      |=> $stable(swi_pend));

  // R3
  always_comb begin
    if (rst_n && reg_addr == A_INFO)
      info_chk: assert (reg_rdata[7:0] == {3'(NUM_CPUS - 1), 5'(NUM_GROUPS - 1)});
  end
endmodule

bind irqd_top irqd_chk #(.NUM_GROUPS(NUM_GROUPS), .NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q),
  .line_en(line_en), .swi_pend(swi_pend), .cpu_ack(cpu_ack),
  .cpu_irq_valid(cpu_irq_valid)
);

// File: tb/tb_irqd_top.sv
module tb_irqd_top;
  import irqd_pkg::*;
  localparam int G = 2, C = 4, N = 64, IDW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [N-1:0] irq_in;
  logic reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0] reg_src_cpu;
  logic [C-1:0] cpu_ack, cpu_irq_valid;
  logic [C*IDW-1:0] cpu_irq_id;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  irqd_top #(.NUM_GROUPS(G), .NUM_CPUS(C)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_src_cpu(reg_src_cpu),
    .reg_rdata(reg_rdata), .cpu_ack(cpu_ack), .cpu_irq_valid(cpu_irq_valid),
    .cpu_irq_id(cpu_irq_id)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [2:0] src = 3'd0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_src_cpu = src;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_out(string req, int c, bit v, int id);
    chk(req, {31'b0, cpu_irq_valid[c]}, {31'b0, v});
    if (v) chk(req, {26'b0, cpu_irq_id[c*IDW +: IDW]}, id);
  endtask

  task automatic ack(int c);
    @(negedge clk); cpu_ack[c] = 1'b1;
    @(negedge clk); cpu_ack[c] = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(int id);
    @(negedge clk); irq_in[id] = 1'b1;
    @(negedge clk); irq_in[id] = 1'b0;
  endtask

  task automatic t_reset();
    chk_rd("R8 ctrl reset", A_CTRL, 32'h0);
    chk_rd("R3 type word", A_INFO, 32'h61);
    chk_rd("R1 enable reset", A_ENSET + 12'd1, 32'h0);
    chk_rd("R6 target reset", A_TGT + 12'd8, 32'h01010101);
    chk_rd("R6 soft target reset", A_TGT, 32'h0);
    chk("R8 no request in reset", {28'b0, cpu_irq_valid}, 32'h0);
  endtask

  task automatic t_level();
    wr(A_CTRL, 32'h1);
    wr(A_ENSET + 12'd1, 32'h100);
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk);
    chk_out("R11 not yet after first edge", 0, 1'b0, 0);
    @(negedge clk);
    chk_out("R5 level pending", 0, 1'b1, 40);
    chk_out("R6 default routes to cpu0 only", 1, 1'b0, 0);
    ack(0);
    chk_out("R10 level unaffected by ack", 0, 1'b1, 40);
    irq_in[40] = 1'b0;
    wait_n(2);
    chk_out("R5 level drops", 0, 1'b0, 0);
  endtask

  task automatic t_edge();
    wr(A_TRIG + 12'd2, 32'h0008_0000);
    chk_rd("R4 edge mode readback", A_TRIG + 12'd2, 32'h0008_0000);
    wr(A_TGT + 12'd10, 32'h01010401);
    wr(A_ENSET + 12'd1, 32'h200);
    pulse(41);
    wait_n(2);
    chk_out("R5 edge latched on cpu2", 2, 1'b1, 41);
    chk_out("R6 not routed to cpu0", 0, 1'b0, 0);
    chk_rd("R2 pending view", A_PCLR + 12'd1, 32'h200);
    ack(2);
    chk_out("R10 ack clears edge", 2, 1'b0, 0);
    pulse(41);
    wait_n(2);
    chk_out("R5 edge again", 2, 1'b1, 41);
    wr(A_PCLR + 12'd1, 32'h200);
    @(negedge clk);
    chk_out("R2 pending cleared", 2, 1'b0, 0);
  endtask

  task automatic t_enable();
    pulse(41);
    wait_n(2);
    wr(A_ENCLR + 12'd1, 32'h0);
    chk_rd("R1 zero bits keep state", A_ENSET + 12'd1, 32'h300);
    wr(A_ENCLR + 12'd1, 32'h200);
    @(negedge clk);
    chk_out("R1 disabled hides request", 2, 1'b0, 0);
    chk_rd("R1 clear readback", A_ENCLR + 12'd1, 32'h100);
    wr(A_ENSET + 12'd1, 32'h200);
    @(negedge clk);
    chk_out("R1 reenable shows held pending", 2, 1'b1, 41);
    wr(A_PCLR + 12'd1, 32'h200);
  endtask

  task automatic t_prio();
    wr(A_ENSET + 12'd1, 32'h102);
    @(negedge clk); irq_in[33] = 1'b1; irq_in[40] = 1'b1;
    wait_n(2);
    chk_out("R9 lowest id first", 0, 1'b1, 33);
    irq_in[33] = 1'b0;
    wait_n(2);
    chk_out("R9 next id", 0, 1'b1, 40);
    irq_in[40] = 1'b0;
    wait_n(2);
  endtask

  task automatic t_swi();
    wr(A_ENSET, 32'h0000FFFF);
    wr(A_SWI, 32'h0005_0005);
    @(negedge clk);
    chk_out("R7 list cpu0", 0, 1'b1, 5);
    chk_out("R7 list cpu2", 2, 1'b1, 5);
    chk_out("R7 list skips cpu1", 1, 1'b0, 0);
    ack(0);
    chk_out("R10 soft ack own cpu", 0, 1'b0, 0);
    chk_out("R10 other cpu keeps", 2, 1'b1, 5);
    wr(A_SWI, 32'h0100_0003, 3'd2);
    @(negedge clk);
    chk_out("R7 others cpu0", 0, 1'b1, 3);
    chk_out("R7 others cpu3", 3, 1'b1, 3);
    chk_out("R7 others skip requester", 2, 1'b1, 5);
    wr(A_SWI, 32'h0200_0002, 3'd1);
    @(negedge clk);
    chk_out("R7 self only", 1, 1'b1, 2);
    wr(A_SWI, 32'h030F_8001);
    @(negedge clk);
    chk_out("R7 filter 3 ignored", 0, 1'b1, 3);
    wr(A_SWI, 32'h0008_8000);
    @(negedge clk);
    chk_out("R7 bit15 no effect", 3, 1'b1, 0);
    chk_rd("R2 soft pending view", A_PCLR, 32'h2D);
    wr(A_PCLR, 32'h0000FFFF);
    @(negedge clk);
    chk("R2 soft clear all cpus", {28'b0, cpu_irq_valid}, 32'h0);
  endtask

  task automatic t_ctrl();
    @(negedge clk); irq_in[40] = 1'b1;
    wait_n(2);
    chk_out("R8 forwarding on", 0, 1'b1, 40);
    wr(A_CTRL, 32'h0);
    @(negedge clk);
    chk_out("R8 forwarding off", 0, 1'b0, 0);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    chk_out("R8 forwarding back", 0, 1'b1, 40);
    irq_in[40] = 1'b0;
    wait_n(2);
  endtask

  task automatic t_fixed();
    wr(A_TRIG + 12'd1, 32'hFFFF_FFFF);
    chk_rd("R4 fixed ids stay level", A_TRIG + 12'd1, 32'h0);
    wr(A_TGT, 32'hFFFF_FFFF);
    chk_rd("R6 soft targets ignore writes", A_TGT, 32'h0);
    wr(A_ENSET, 32'hFFFF_FFFF);
    pulse(20);
    wait_n(2);
    chk_out("R4 fixed id does not latch", 0, 1'b0, 0);
    @(negedge clk); irq_in[5] = 1'b1;
    wait_n(2);
    chk("R12 low inputs ignored", {28'b0, cpu_irq_valid}, 32'h0);
    chk_rd("R12 no pending from low inputs", A_PCLR, 32'h0);
    irq_in[5] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0;
    reg_wdata = '0; reg_src_cpu = '0; cpu_ack = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_level();
    t_edge();
    t_enable();
    t_prio();
    t_swi();
    t_ctrl();
    t_fixed();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule